// File: doc/BRIEF.md
# Serial Configuration PROM Reader

This block fetches 16-bit words from a three-wire serial configuration PROM, the kind that holds a board's station address and boot settings. A client presents a word address together with an address-width select. The block frames a read command on the chip-select, shift-clock and serial-out pins. It then clocks the word back in on the serial-in pin and returns it with a one-cycle completion pulse. Every pin phase lasts a programmable number of system clocks, so one design can serve slow and fast parts.

When reset is released, the block runs a start-up sequence of its own before it takes any client traffic. It first reads word 0 with eight address bits and uses the result to decide how wide every later address is. It then reads the three words that follow the station-address base and assembles a 48-bit station address from them. Each of those words is taken low byte first.

Top module: `cfg_prom_reader`

## Requirements
- R1: While reset is asserted and until the start-up sequence finishes, `req_ready` and `boot_done` are low. The start-up sequence makes exactly four reads. The first is word 0, sent with 8 address bits (27 shift-clock pulses). Once `boot_done` rises it stays high until the next reset.
- R2: `addr_wide` is 1 exactly when word 0 read back as 16'h8129. Any other value, including 16'h8128, gives 0.
- R3: `station_addr` is built from words 7, 8 and 9, low byte first. Bits [47:40] hold word 7 bits [7:0], bits [39:32] hold word 7 bits [15:8], and so on down to bits [7:0], which hold word 9 bits [15:8].
- R4: A frame starts with the opcode bits 1,1,0 and continues with the address, MSB first, for 3+aw bits, where aw is 8 if `req_wide`=1 and 6 otherwise. Each bit is placed on `prom_sdo` while `prom_sclk` is low, and then the clock rises. `prom_sdo` never changes while `prom_sclk` stays high.
- R5: After the command, exactly 16 clock pulses follow, for 3+aw+16 pulses per frame. `prom_sdi` is sampled while `prom_sclk` is high, and the first bit sampled becomes bit 15 of `rsp_word`.
- R6: For one phase after a request is accepted, `prom_cs` is held low, and then it goes high before the first clock. It drops for the last phase of the frame. `prom_sclk` is high only while `prom_cs` is high. Both pins are low whenever `req_ready` is high.
- R7: Each level of `prom_sclk` lasts at least HALF_PERIOD clocks (a value below 1 counts as 1). `rsp_done` rises exactly (36+2·(3+aw))·HALF_PERIOD clocks after the accepting edge.
- R8: `req_ready` falls in the cycle after a request is accepted. A `req_valid` raised while `req_ready` is low starts no frame.
- R9: When `req_wide`=0, only `req_addr[5:0]` is sent, and the upper address bits have no effect.
- R10: `prom_sdo` is low during the data phase and whenever `prom_cs` is low.
- R11: `rsp_done` is a single-cycle pulse, and `rsp_word` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request strobe, taken when `req_ready` is high |
| req_addr | input | ADDR_MAX_W | Word address of the request |
| req_wide | input | 1 | 1: send 8 address bits, 0: send 6 |
| req_ready | output | 1 | Start-up finished and engine idle |
| rsp_done | output | 1 | One-cycle pulse when a client read completes |
| rsp_word | output | WORD_W | Word returned by the last read |
| boot_done | output | 1 | Start-up sequence complete |
| addr_wide | output | 1 | Width chosen by the word-0 autodetect |
| station_addr | output | MAC_W | Station address assembled at start-up |
| prom_cs | output | 1 | PROM chip select, active high |
| prom_sclk | output | 1 | PROM shift clock |
| prom_sdo | output | 1 | Serial data to the PROM |
| prom_sdi | input | 1 | Serial data from the PROM |

## Verification
The bound checker watches the pin-level rules on every cycle: the clock only toggles under chip select, data is stable while the clock is high, data stays quiet outside a selected frame, and each clock level lasts at least the minimum number of clocks. It also checks the handshake rules: ready drops after an accept, ready implies start-up is done, start-up completion is sticky, and the completion signal is a single pulse. Only the bench's scenarios can show the values that come back. These are the opcode and address order as the PROM model decodes them, the word returned for every address in both widths, the autodetect decision on either side of the signature, the byte order of the station address, and the exact latency and chip-select placement.

// File: rtl/prom_pkg.sv
// Shared constants and state types for the serial PROM reader.
// Assumes a three-wire PROM whose commands start with an always-one start bit.
package prom_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_READ  = 3'b110;
    localparam logic [OP_W-1:0] OP_WRITE = 3'b101;
    localparam logic [OP_W-1:0] OP_ERASE = 3'b111;
    localparam logic [15:0] WIDE_SIGNATURE = 16'h8129;

    typedef enum logic [3:0] {
        PH_IDLE, PH_SEL_LO, PH_SEL_HI, PH_CMD_LO, PH_CMD_HI,
        PH_GAP, PH_DAT_HI, PH_DAT_LO, PH_END
    } phase_e;

    typedef enum logic [1:0] {
        BT_ISSUE, BT_WAIT, BT_READY
    } boot_e;
endpackage

// File: rtl/prom_phase_timer.sv
// Phase timer: while run is high, it flags the last system clock of each pin phase.
// Assumes HALF_PERIOD >= 1 and clamps smaller values to 1.
module prom_phase_timer #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int HP_EFF = (HALF_PERIOD < 1) ? 1 : HALF_PERIOD;
    localparam int CW     = $clog2(HP_EFF + 1);
    localparam logic [CW-1:0] LAST = CW'(HP_EFF - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within the current phase and restart at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (phase_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The phase ends on its last clock.
    always_comb phase_end = run && (cnt == LAST);
endmodule

// File: rtl/prom_frame_engine.sv
// Frame engine: sends one read frame (select, command, data, deselect) and returns the word.
// Assumes prom_sdi is already synchronous to clk, because at HALF_PERIOD=1 there is no slack for a synchronizer.
module prom_frame_engine
    import prom_pkg::*;
#(
    parameter int ADDR_MAX_W = 8,
    parameter int ADDR_MIN_W = 6,
    parameter int WORD_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  wide,
    input  logic [ADDR_MAX_W-1:0] addr,
    input  logic                  phase_end,
    input  logic                  sdi,
    output logic                  busy,
    output logic                  done,
    output logic [WORD_W-1:0]     word,
    output logic                  cs,
    output logic                  sclk,
    output logic                  sdo
);
    localparam int FRAME_W = OP_W + ADDR_MAX_W;
    localparam int PAD_W   = ADDR_MAX_W - ADDR_MIN_W;
    localparam int CNT_W   = $clog2(FRAME_W + WORD_W + 1);
    localparam logic [CNT_W-1:0] WIDE_BITS   = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] NARROW_BITS = CNT_W'(OP_W + ADDR_MIN_W);
    localparam logic [CNT_W-1:0] DATA_BITS   = CNT_W'(WORD_W);

    phase_e              state;
    logic [FRAME_W-1:0]  frame_sr;
    logic [FRAME_W-1:0]  wide_frame;
    logic [FRAME_W-1:0]  narrow_frame;
    logic [CNT_W-1:0]    bits_left;
    logic [WORD_W-1:0]   word_sr;
    logic [WORD_W-1:0]   word_q;
    logic                done_q;

    // Wide frames carry the full address. Narrow frames left-align the short address.
    always_comb wide_frame = {OP_READ, addr};
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb narrow_frame = {OP_READ, addr[ADDR_MIN_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            always_comb narrow_frame = {OP_READ, addr};
        end
    endgenerate

    // Sequence the phases of one frame, shifting the command out and the word in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PH_IDLE;
            frame_sr  <= '0;
            bits_left <= '0;
            word_sr   <= '0;
            word_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (start) begin
                        state     <= PH_SEL_LO;
                        frame_sr  <= wide ? wide_frame : narrow_frame;
                        bits_left <= wide ? WIDE_BITS : NARROW_BITS;
                    end
                end
                PH_SEL_LO: if (phase_end) state <= PH_SEL_HI;
                PH_SEL_HI: if (phase_end) state <= PH_CMD_LO;
                PH_CMD_LO: if (phase_end) state <= PH_CMD_HI;
                PH_CMD_HI: begin
                    if (phase_end) begin
                        frame_sr <= frame_sr << 1;
                        if (bits_left == CNT_W'(1)) begin
                            state     <= PH_GAP;
                            bits_left <= DATA_BITS;
                        end else begin
                            state     <= PH_CMD_LO;
                            bits_left <= bits_left - 1'b1;
                        end
                    end
                end
                PH_GAP: if (phase_end) state <= PH_DAT_HI;
                PH_DAT_HI: begin
                    if (phase_end) begin
                        word_sr <= {word_sr[WORD_W-2:0], sdi};
                        state   <= PH_DAT_LO;
                    end
                end
                PH_DAT_LO: begin
                    if (phase_end) begin
                        if (bits_left == CNT_W'(1)) begin
                            state <= PH_END;
                        end else begin
                            state     <= PH_DAT_HI;
                            bits_left <= bits_left - 1'b1;
                        end
                    end
                end
                PH_END: begin
                    if (phase_end) begin
                        state  <= PH_IDLE;
                        word_q <= word_sr;
                        done_q <= 1'b1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // Decode the pin levels from the phase state.
    always_comb begin
        cs   = (state == PH_SEL_HI) || (state == PH_CMD_LO) || (state == PH_CMD_HI) ||
               (state == PH_GAP)    || (state == PH_DAT_HI) || (state == PH_DAT_LO);
        sclk = (state == PH_CMD_HI) || (state == PH_DAT_HI);
        sdo  = ((state == PH_CMD_LO) || (state == PH_CMD_HI)) && frame_sr[FRAME_W-1];
        busy = (state != PH_IDLE);
        done = done_q;
        word = word_q;
    end
endmodule

// File: rtl/prom_boot_seq.sv
// Start-up sequencer: reads word 0 to pick the address width, then reads the station-address words.
// After that it passes client requests through to the frame engine. Assumes MAC_W is a multiple of WORD_W.
module prom_boot_seq
    import prom_pkg::*;
#(
    parameter int ADDR_MAX_W   = 8,
    parameter int WORD_W       = 16,
    parameter int MAC_W        = 48,
    parameter int STATION_BASE = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  user_valid,
    input  logic [ADDR_MAX_W-1:0] user_addr,
    input  logic                  user_wide,
    input  logic                  eng_busy,
    input  logic                  eng_done,
    input  logic [WORD_W-1:0]     eng_word,
    output logic                  eng_start,
    output logic [ADDR_MAX_W-1:0] eng_addr,
    output logic                  eng_wide,
    output logic                  user_ready,
    output logic                  user_done,
    output logic                  boot_done,
    output logic                  addr_wide,
    output logic [MAC_W-1:0]      station
);
    localparam int NUM_WORDS = MAC_W / WORD_W;
    localparam int NBYTES    = WORD_W / 8;
    localparam int STEP_W    = $clog2(NUM_WORDS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WORDS);

    boot_e               bstate;
    logic [STEP_W-1:0]   step;
    logic                wide_q;
    logic                user_owned;
    logic [WORD_W-1:0]   swapped;
    logic [ADDR_MAX_W-1:0] boot_addr;

    // Reverse the byte order so the low byte lands first in the station address.
    always_comb begin
        swapped = '0;
        for (int b = 0; b < NBYTES; b++) begin
            swapped[WORD_W-1-8*b -: 8] = eng_word[8*b +: 8];
        end
    end

    // Step 0 reads word 0. Steps 1..N read the station words from the base address up.
    always_comb boot_addr = (step == '0) ? '0
                          : ADDR_MAX_W'(STATION_BASE) + ADDR_MAX_W'(step) - ADDR_MAX_W'(1);

    // Route either the start-up read or the client request to the engine.
    always_comb begin
        user_ready = (bstate == BT_READY) && !eng_busy;
        if (bstate == BT_READY) begin
            eng_start = user_valid && !eng_busy;
            eng_addr  = user_addr;
            eng_wide  = user_wide;
        end else begin
            eng_start = (bstate == BT_ISSUE) && !eng_busy;
            eng_addr  = boot_addr;
            eng_wide  = (step == '0) ? 1'b1 : wide_q;
        end
        user_done = eng_done && user_owned;
        boot_done = (bstate == BT_READY);
        addr_wide = wide_q;
    end

    // Walk the start-up steps and capture the detected width and the station words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bstate     <= BT_ISSUE;
            step       <= '0;
            wide_q     <= 1'b0;
            station    <= '0;
            user_owned <= 1'b0;
        end else begin
            case (bstate)
                BT_ISSUE: if (!eng_busy) bstate <= BT_WAIT;
                BT_WAIT: begin
                    if (eng_done) begin
                        if (step == '0) begin
                            wide_q <= (eng_word == WIDE_SIGNATURE);
                        end
                        for (int j = 0; j < NUM_WORDS; j++) begin
                            if (step == STEP_W'(j + 1)) begin
                                station[MAC_W-1-WORD_W*j -: WORD_W] <= swapped;
                            end
                        end
                        if (step == LAST_STEP) begin
                            bstate <= BT_READY;
                        end else begin
                            step   <= step + 1'b1;
                            bstate <= BT_ISSUE;
                        end
                    end
                end
                BT_READY: begin
                    if (eng_start) begin
                        user_owned <= 1'b1;
                    end else if (eng_done) begin
                        user_owned <= 1'b0;
                    end
                end
                default: bstate <= BT_ISSUE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_prom_reader.sv
// Top level of the serial configuration PROM reader: start-up sequencer, frame engine and phase timer.
// Assumes a single clock domain and an active-high PROM chip select.
module cfg_prom_reader #(
    parameter int HALF_PERIOD  = 4,
    parameter int ADDR_MAX_W   = 8,
    parameter int ADDR_MIN_W   = 6,
    parameter int WORD_W       = 16,
    parameter int MAC_W        = 48,
    parameter int STATION_BASE = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_MAX_W-1:0] req_addr,
    input  logic                  req_wide,
    output logic                  req_ready,
    output logic                  rsp_done,
    output logic [WORD_W-1:0]     rsp_word,
    output logic                  boot_done,
    output logic                  addr_wide,
    output logic [MAC_W-1:0]      station_addr,
    output logic                  prom_cs,
    output logic                  prom_sclk,
    output logic                  prom_sdo,
    input  logic                  prom_sdi
);
    logic                  eng_start;
    logic                  eng_busy;
    logic                  eng_done;
    logic                  eng_wide;
    logic [ADDR_MAX_W-1:0] eng_addr;
    logic                  phase_end;

    prom_phase_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .phase_end (phase_end)
    );

    prom_frame_engine #(
        .ADDR_MAX_W (ADDR_MAX_W),
        .ADDR_MIN_W (ADDR_MIN_W),
        .WORD_W     (WORD_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .wide      (eng_wide),
        .addr      (eng_addr),
        .phase_end (phase_end),
        .sdi       (prom_sdi),
        .busy      (eng_busy),
        .done      (eng_done),
        .word      (rsp_word),
        .cs        (prom_cs),
        .sclk      (prom_sclk),
        .sdo       (prom_sdo)
    );

    prom_boot_seq #(
        .ADDR_MAX_W   (ADDR_MAX_W),
        .WORD_W       (WORD_W),
        .MAC_W        (MAC_W),
        .STATION_BASE (STATION_BASE)
    ) u_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .user_valid (req_valid),
        .user_addr  (req_addr),
        .user_wide  (req_wide),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .eng_word   (rsp_word),
        .eng_start  (eng_start),
        .eng_addr   (eng_addr),
        .eng_wide   (eng_wide),
        .user_ready (req_ready),
        .user_done  (rsp_done),
        .boot_done  (boot_done),
        .addr_wide  (addr_wide),
        .station    (station_addr)
    );
endmodule

// File: rtl/prom_reader_chk.sv
// Checker for the PROM reader: pin protocol and handshake properties, bound to the top module.
// Assumes synchronous active-low reset. The half-period window is tracked with a saturating counter.
module prom_reader_chk #(
    parameter int HALF_PERIOD = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic boot_done,
    input logic prom_cs,
    input logic prom_sclk,
    input logic prom_sdo
);
    localparam int HP_EFF = (HALF_PERIOD < 1) ? 1 : HALF_PERIOD;
    localparam int RW     = $clog2(HP_EFF + 1);
    localparam logic [RW-1:0] HP_V = RW'(HP_EFF);

    logic          prev_sclk;
    logic [RW-1:0] level_run;

    // Count how many cycles the shift clock has held its current level, saturating at the half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            level_run <= '0;
        end else begin
            prev_sclk <= prom_sclk;
            if (prom_sclk != prev_sclk) begin
                level_run <= RW'(1);
            end else if (level_run < HP_V) begin
                level_run <= level_run + 1'b1;
            end
        end
    end

    AST_READY_NEEDS_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> boot_done); // R1
    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done); // R1
    AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_sclk && $past(prom_sclk)) |-> $stable(prom_sdo)); // R4
    AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        prom_sclk |-> prom_cs); // R6
    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!prom_cs && !prom_sclk)); // R6
    AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_sclk != prev_sclk) |-> (level_run >= HP_V)); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_SDO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        prom_sdo |-> prom_cs); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R11
endmodule

bind cfg_prom_reader prom_reader_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .boot_done (boot_done),
    .prom_cs   (prom_cs),
    .prom_sclk (prom_sclk),
    .prom_sdo  (prom_sdo)
);

// File: tb/sim_cfg_prom_reader.sv
// Bench: behavioural serial PROM model, start-up scenarios and exhaustive read sweeps.
module sim_cfg_prom_reader;
    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        req_wide = 1'b0;
    logic        req_ready, rsp_done, boot_done, addr_wide;
    logic [15:0] rsp_word;
    logic [47:0] station_addr;
    logic        prom_cs, prom_sclk, prom_sdo;
    logic        prom_sdi = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_prom_reader #(.HALF_PERIOD(HP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wide(req_wide), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_word(rsp_word), .boot_done(boot_done), .addr_wide(addr_wide),
        .station_addr(station_addr), .prom_cs(prom_cs), .prom_sclk(prom_sclk),
        .prom_sdo(prom_sdo), .prom_sdi(prom_sdi)
    );

    // PROM model configuration
    bit          model_wide = 1'b1;
    logic [15:0] word0_val  = 16'h8129;

    function automatic logic [15:0] mem_word(input int a);
        if (a == 0) return word0_val;
        return 16'((a * 1031 + 4951) & 16'hFFFF);
    endfunction

    // PROM model state
    int          bitcnt = 0;
    int          hdr_len = 11;
    int          idx = 0;
    logic [15:0] hdr_sr = '0;
    logic [15:0] cur_word = '0;
    int          frames = 0;
    int          boot_base = 0;
    int          last_pulses = 0;
    int          first_pulses = 0;
    logic [15:0] last_hdr = '0;
    int          sdo_bad_cnt = 0;

    // Select rising clears the model. A clock rising shifts in the header or shifts out data.
    always @(posedge prom_cs or posedge prom_sclk) begin
        if (!prom_sclk) begin
            bitcnt   = 0;
            hdr_sr   = '0;
            prom_sdi = 1'b0;
        end else if (prom_cs) begin
            hdr_len = model_wide ? 11 : 9;
            if (bitcnt < hdr_len) hdr_sr = {hdr_sr[14:0], prom_sdo};
            else if (prom_sdo) sdo_bad_cnt++;
            bitcnt++;
            if (bitcnt == hdr_len) begin
                cur_word = mem_word(model_wide ? int'(hdr_sr[7:0]) : int'(hdr_sr[5:0]));
                prom_sdi = 1'b0;
            end else if (bitcnt > hdr_len) begin
                idx = 15 - (bitcnt - hdr_len - 1);
                prom_sdi = (idx >= 0) ? cur_word[idx] : 1'b0;
            end
        end
    end

    // Select falling closes a frame and records what the model saw.
    always @(negedge prom_cs) begin
        if (frames == boot_base) first_pulses = bitcnt;
        last_pulses = bitcnt;
        last_hdr    = hdr_sr;
        frames++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_station();
        logic [15:0] w7, w8, w9;
        w7 = mem_word(7); w8 = mem_word(8); w9 = mem_word(9);
        return {w7[7:0], w7[15:8], w8[7:0], w8[15:8], w9[7:0], w9[15:8]};
    endfunction

    task automatic do_boot(input bit mw, input logic [15:0] w0,
                           input bit exp_wide, input bit chk_station);
        int k;
        model_wide = mw;
        word0_val  = w0;
        req_valid  = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!req_ready && !boot_done && !prom_cs && !prom_sclk, "R1", "reset state",
            {req_ready, boot_done, prom_cs, prom_sclk}, 0);
        boot_base = frames;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R1", "ready low during start-up", req_ready, 0);
        k = 0;
        while (!boot_done && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(boot_done, "R1", "start-up completes", boot_done, 1);
        chk(first_pulses == 27, "R1", "word-0 read uses 8 address bits", first_pulses, 27);
        chk(frames - boot_base == 4, "R1", "start-up read count", frames - boot_base, 4);
        chk(addr_wide == exp_wide, "R2", "autodetected width", addr_wide, exp_wide);
        if (chk_station)
            chk(station_addr == exp_station(), "R3", "station address",
                station_addr, exp_station());
        chk(req_ready, "R8", "ready after start-up", req_ready, 1);
    endtask

    task automatic do_read(input logic [7:0] a, input bit w);
        int k, n, fr0, bad0, done_k, aw;
        logic [5:0]  lo;
        logic [15:0] exp;
        logic [7:0]  seen_addr;
        logic [2:0]  seen_op;
        aw  = w ? 8 : 6;
        n   = (36 + 2 * (3 + aw)) * HP;
        lo  = a[5:0];
        exp = mem_word(w ? int'(a) : int'(lo));
        chk(req_ready, "R8", "ready before request", req_ready, 1);
        fr0  = frames;
        bad0 = sdo_bad_cnt;
        req_valid = 1'b1; req_addr = a; req_wide = w;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        done_k = -1;
        while (k < n + 10) begin
            if (k == HP - 1) chk(!prom_cs, "R6", "select low before frame", prom_cs, 0);
            if (k == HP)     chk(prom_cs, "R6", "select high before clock", prom_cs, 1);
            if (k == 3*HP-1) chk(!prom_sclk, "R4", "clock low during first bit setup", prom_sclk, 0);
            if (k == 3*HP)   chk(prom_sclk, "R4", "first clock rise", prom_sclk, 1);
            if (k == n-HP-1) chk(prom_cs, "R6", "select held through data", prom_cs, 1);
            if (k == n-HP)   chk(!prom_cs, "R6", "select dropped in last phase", prom_cs, 0);
            if (rsp_done) begin
                done_k = k;
                break;
            end
            @(negedge clk);
            k++;
        end
        chk(done_k == n, "R7", "completion latency", done_k, n);
        chk(rsp_word == exp, "R5", "returned word", rsp_word, exp);
        chk(last_pulses == 3 + aw + 16, "R5", "clock pulses per frame", last_pulses, 3 + aw + 16);
        seen_op   = w ? last_hdr[10:8] : last_hdr[8:6];
        seen_addr = w ? last_hdr[7:0] : {2'b00, last_hdr[5:0]};
        chk(seen_op == 3'b110, "R4", "read opcode", seen_op, 3'b110);
        if (w) chk(seen_addr == a, "R4", "address bits", seen_addr, a);
        else   chk(seen_addr == {2'b00, lo}, "R9", "narrow address ignores upper bits",
                   seen_addr, {2'b00, lo});
        chk(sdo_bad_cnt == bad0, "R10", "data-out low in data phase", sdo_bad_cnt - bad0, 0);
        chk(frames == fr0 + 1, "R8", "one frame per request", frames - fr0, 1);
        @(negedge clk);
        chk(!rsp_done, "R11", "done is one cycle", rsp_done, 0);
    endtask

    task automatic busy_test();
        int k, fr0;
        logic [15:0] exp;
        exp = mem_word(8'h21);
        fr0 = frames;
        req_valid = 1'b1; req_addr = 8'h21; req_wide = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!rsp_done && k < 1000) begin
            if (k == 10) begin req_valid = 1'b1; req_addr = 8'h55; end
            if (k == 20) req_valid = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(rsp_word == exp, "R8", "busy request did not disturb word", rsp_word, exp);
        repeat (4 * HP + 5) @(negedge clk);
        chk(frames == fr0 + 1, "R8", "request while busy started no frame", frames - fr0, 1);
        chk(!prom_cs && req_ready, "R6", "idle after frame", {prom_cs, req_ready}, 1);
        chk(rsp_word == exp, "R11", "word held after done", rsp_word, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Scenario A: 8-bit part carrying the signature
        do_boot(1'b1, 16'h8129, 1'b1, 1'b1);
        for (int a = 0; a < 256; a++) do_read(8'(a), 1'b1);
        busy_test();
        // Scenario B: 6-bit part. Word 0 comes back shifted, so it is not the signature.
        do_boot(1'b0, 16'h1234, 1'b0, 1'b1);
        for (int a = 0; a < 64; a++) do_read(8'((a | ((a * 37) << 6)) & 8'hFF), 1'b0);
        // Scenario C: one below the signature selects the narrow width
        do_boot(1'b1, 16'h8128, 1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule